// File: doc/BRIEF.md
# Cascadable Latched Shift Driver

This block is a synchronous digital model of an eight-channel serial-to-parallel sink driver. A host streams bits into an internal shift register with a serial clock. It then pulses a load line to copy the register into a holding latch. The latched pattern reaches the channel outputs only while an active-low strobe is held low, so each output pulse is exactly as long as the strobe pulse. The last shift stage is exposed on a serial output, so several blocks can be chained on shared serial clock, load and strobe lines. Each link adds one group of channels.

The block runs on a fast system clock. It oversamples its five device pins through synchronizers and detects rising edges in the system clock domain. A power-enable input puts the block into a standby state. In standby all channels are dark, serial clock and load edges are ignored, and the stored bits are kept. A built-in timing monitor flags serial data that changes too close to a serial clock rising edge, before or after it. Distances are counted in system clock cycles.

Top module: `sipo_sink_driver`

## Requirements
- R1: While `rst_n` is low, and after its release with idle pins, `chan_on`, `ser_out` and `timing_err` are all zero.
- R2: Each rising edge of `ser_clk` (power enabled) shifts `ser_data` into stage 0 and moves every stage up by one. `ser_out` always shows the top stage, so it repeats the bit shifted in `N_CH` edges earlier.
- R3: A rising edge of `load` (power enabled) copies the shift register into the latch. The first of `N_CH` bits shifted lands on `chan_on[N_CH-1]` and the last lands on `chan_on[0]`. Sending a byte MSB first therefore makes `chan_on` equal to that byte.
- R4: Between `load` rising edges the latch keeps its value, so shifting new data never changes `chan_on`.
- R5: `chan_on` equals the latch while `strobe_n` is low and is all zero while it is high. An output pulse lasts exactly as many system clock cycles as the strobe was low.
- R6: While `power_en` is low, `chan_on` is all zero and rising edges of `ser_clk` and `load` have no effect. `ser_out` holds, and the old latch pattern returns when power is enabled again.
- R7: A `ser_clk` rise that comes fewer than `SETUP_CYC` system cycles after a `ser_data` change (same cycle included) pulses `timing_err[0]` (setup) for one cycle.
- R8: A `ser_data` change that comes 1 to `HOLD_CYC-1` system cycles after a `ser_clk` rise pulses `timing_err[1]` (hold) for one cycle. The two error bits are never high together, and correctly spaced traffic raises neither.
- R9: With `ser_out` of one block wired to `ser_data` of a second, and the control lines shared, `2*N_CH` shifted bits fill both. The first `N_CH` bits sent end up on the second block's channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the device pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data in |
| load | input | 1 | Latch load; the register is copied on its rising edge |
| strobe_n | input | 1 | Active-low output strobe |
| power_en | input | 1 | High for operation, low for standby |
| ser_out | output | 1 | Top shift stage, used as the cascade output |
| chan_on | output | N_CH | Channel sink enables, 1 = sinking |
| timing_err | output | 2 | Bit 0 setup violation, bit 1 hold violation (one-cycle pulses) |

## Verification
The shift path is driven with alternating, constant and mixed byte patterns. A bit-by-bit walk on `ser_out` separates a correct delay line from reversed or stuck stages, and the latched byte exposes a swapped channel order. Strobe pulses of several widths measure the output pulse length, so added or lost gating cycles show up. Standby is exercised by sending a distinct byte and a load pulse while powered down, which tells a held register apart from one that kept shifting. The timing monitor gets one deliberate setup fault, one hold fault and a long run of clean traffic, so false alarms are separated from missed ones.

// File: rtl/sipo_pkg.sv
// Package: shared pin bundle type and error bit positions for the
// serial-to-parallel sink driver. Assumes nothing beyond IEEE 1800-2017.
package sipo_pkg;

    // Bundle of the five oversampled device pins; first field is the MSB.
    typedef struct packed {
        logic pwr;
        logic strobe_n;
        logic load;
        logic sdata;
        logic sclk;
    } pin_bus_t;

    localparam int PIN_W = $bits(pin_bus_t);

    // Idle pin levels used as synchronizer reset values (strobe inactive high).
    localparam pin_bus_t PIN_IDLE = '{pwr: 1'b0, strobe_n: 1'b1, load: 1'b0,
                                      sdata: 1'b0, sclk: 1'b0};

    // Positions inside the timing error vector.
    localparam int ERR_SETUP = 0;
    localparam int ERR_HOLD  = 1;
    localparam int ERR_W     = 2;

endpackage

// File: rtl/sipo_in_sync.sv
// Module: multi-bit pin synchronizer with rising-edge detection.
// Each bit passes a STAGES-deep flop chain; rise[b] is high for one
// cycle after the synchronized level goes from 0 to 1.
// Assumes: STAGES >= 2, inputs are asynchronous single-bit levels.
module sipo_in_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] rise
);

    logic [W-1:0] prev_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Move one pin bit through its synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= {chain_q[STAGES-2:0], din[b]};
        end

        assign dout[b] = chain_q[STAGES-1];
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= dout;
    end

    assign rise = dout & ~prev_q;

endmodule

// File: rtl/sipo_shift_reg.sv
// Module: serial shift register. On shift_en, din enters stage 0 and every
// stage moves up one place; the top stage is the serial/cascade output.
// Assumes: DEPTH >= 2, shift_en is a single-cycle pulse per serial edge.
module sipo_shift_reg #(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [DEPTH-1:0] stages,
    output logic             top_bit
);

    logic [DEPTH-1:0] stage_q;

    // Shift one bit in at stage 0 on every qualified serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q <= '0;
        else if (shift_en) stage_q <= {stage_q[DEPTH-2:0], din};
    end

    assign stages  = stage_q;
    assign top_bit = stage_q[DEPTH-1];

endmodule

// File: rtl/sipo_out_stage.sv
// Module: holding latch and strobe gate. load_en copies the shift register
// into the latch; channel outputs are registered and show the latch only
// while the strobe is active and power is on, otherwise all zero.
// Assumes: load_en already qualified with power; strb_act is active high.
module sipo_out_stage #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic            strb_act,
    input  logic            pwr_on,
    input  logic [N_CH-1:0] shift_bits,
    output logic [N_CH-1:0] latch_bits,
    output logic [N_CH-1:0] chan
);

    logic [N_CH-1:0] latch_q;
    logic [N_CH-1:0] chan_q;
    logic            gate_open;

    assign gate_open = strb_act & pwr_on;

    // Capture the shift register on a qualified load edge; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= '0;
        else if (load_en) latch_q <= shift_bits;
    end

    // Register the gated channel enables so pulse width tracks the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= gate_open ? latch_q : '0;
    end

    assign latch_bits = latch_q;
    assign chan       = chan_q;

endmodule

// File: rtl/sipo_timing_mon.sv
// Module: serial data setup/hold monitor in system clock cycles.
// Setup fault: an edge arrives fewer than SETUP_CYC cycles after a data
// change (same cycle counts). Hold fault: data changes 1..HOLD_CYC-1 cycles
// after an edge. Faults are registered one-cycle pulses.
// Assumes: data_s and edge_en come through equal synchronizer delays;
// SETUP_CYC >= 1, HOLD_CYC >= 1.
module sipo_timing_mon
    import sipo_pkg::*;
#(
    parameter int SETUP_CYC = 3,
    parameter int HOLD_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_s,
    input  logic             edge_en,
    output logic [ERR_W-1:0] err
);

    localparam int SW = $clog2(SETUP_CYC + 1);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [SW-1:0] SETUP_SAT = SW'(SETUP_CYC);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC - 1);

    logic          data_prev_q;
    logic          data_chg;
    logic [SW-1:0] since_chg_q;
    logic [HW-1:0] hold_left_q;
    logic          setup_bad;
    logic          hold_bad;
    logic [ERR_W-1:0] err_q;

    assign data_chg = data_s ^ data_prev_q;

    // Keep the previous synchronized data level to spot changes.
    always_ff @(posedge clk) begin
        if (!rst_n) data_prev_q <= 1'b0;
        else        data_prev_q <= data_s;
    end

    // Count cycles since the last data change, saturating at SETUP_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n)                       since_chg_q <= SETUP_SAT;
        else if (data_chg)                since_chg_q <= '0;
        else if (since_chg_q != SETUP_SAT) since_chg_q <= since_chg_q + 1'b1;
    end

    // Open a hold window on each edge and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_left_q <= '0;
        else if (edge_en)            hold_left_q <= HOLD_LOAD;
        else if (hold_left_q != '0)  hold_left_q <= hold_left_q - 1'b1;
    end

    assign setup_bad = edge_en & (data_chg | (int'(since_chg_q) < SETUP_CYC - 1));
    assign hold_bad  = data_chg & ~edge_en & (hold_left_q != '0);

    // Register the fault pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else begin
            err_q[ERR_SETUP] <= setup_bad;
            err_q[ERR_HOLD]  <= hold_bad;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/sipo_sink_driver.sv
// Module: top of the cascadable latched shift driver. Oversamples the five
// device pins, shifts serial data on serial clock rises, latches on load
// rises, gates the latch onto the channels with the active-low strobe, and
// holds everything dark and frozen in standby. A monitor reports serial
// setup/hold faults.
// Assumes: clk is several times faster than ser_clk; pins are asynchronous.
module sipo_sink_driver
    import sipo_pkg::*;
#(
    parameter int N_CH        = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SETUP_CYC   = 3,
    parameter int HOLD_CYC    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_clk,
    input  logic            ser_data,
    input  logic            load,
    input  logic            strobe_n,
    input  logic            power_en,
    output logic            ser_out,
    output logic [N_CH-1:0] chan_on,
    output logic [1:0]      timing_err
);

    pin_bus_t        raw_pins;
    logic [PIN_W-1:0] syn_v;
    logic [PIN_W-1:0] rise_v;
    pin_bus_t        syn;
    pin_bus_t        rise;

    logic            pwr_on;
    logic            strb_act;
    logic            shift_en;
    logic            load_en;
    logic [N_CH-1:0] shift_q;
    logic [N_CH-1:0] latch_q;
    logic [ERR_W-1:0] err_v;

    assign raw_pins = '{pwr: power_en, strobe_n: strobe_n, load: load,
                        sdata: ser_data, sclk: ser_clk};

    sipo_in_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_pins),
        .dout  (syn_v),
        .rise  (rise_v)
    );

    assign syn  = pin_bus_t'(syn_v);
    assign rise = pin_bus_t'(rise_v);

    assign pwr_on   = syn.pwr;
    assign strb_act = ~syn.strobe_n;
    assign shift_en = rise.sclk & pwr_on;
    assign load_en  = rise.load & pwr_on;

    sipo_shift_reg #(
        .DEPTH (N_CH)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (syn.sdata),
        .stages   (shift_q),
        .top_bit  (ser_out)
    );

    sipo_out_stage #(
        .N_CH (N_CH)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .strb_act   (strb_act),
        .pwr_on     (pwr_on),
        .shift_bits (shift_q),
        .latch_bits (latch_q),
        .chan       (chan_on)
    );

    sipo_timing_mon #(
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_s  (syn.sdata),
        .edge_en (shift_en),
        .err     (err_v)
    );

    assign timing_err = err_v;

endmodule

// File: rtl/sipo_sink_driver_chk.sv
// Module: assertion checker for sipo_sink_driver, attached by bind below.
// Assumes: signals connected are the top's internal shift/latch state and
// qualified enables.
module sipo_sink_driver_chk #(
    parameter int N_CH = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pwr_on,
    input logic            strb_act,
    input logic            shift_en,
    input logic            load_en,
    input logic [N_CH-1:0] shift_q,
    input logic [N_CH-1:0] latch_q,
    input logic [N_CH-1:0] chan_on,
    input logic [1:0]      timing_err
);

    // R1: outputs are clear on the first cycle after reset release.
    a_r1_clear_at_release: assert property (@(posedge clk)
        $rose(rst_n) |-> (chan_on == '0 && timing_err == '0));

    // R2: a shift moves every stage up by one place.
    a_r2_stage_step: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> shift_q[N_CH-1:1] == $past(shift_q[N_CH-2:0]));

    // R3: a load copies the shift register into the latch.
    a_r3_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> latch_q == $past(shift_q));

    // R4: the latch keeps its value without a load.
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(latch_q));

    // R5: an inactive strobe leaves the channels dark.
    a_r5_strobe_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_act |=> chan_on == '0);

    // R6: standby darkens the channels and freezes the shift register.
    a_r6_standby_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> chan_on == '0);
    a_r6_standby_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> $stable(shift_q));

    // R8: setup and hold faults never pulse together.
    a_r8_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(timing_err));

endmodule

bind sipo_sink_driver sipo_sink_driver_chk #(.N_CH(N_CH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_on     (pwr_on),
    .strb_act   (strb_act),
    .shift_en   (shift_en),
    .load_en    (load_en),
    .shift_q    (shift_q),
    .latch_q    (latch_q),
    .chan_on    (chan_on),
    .timing_err (timing_err)
);

// File: tb/test_sipo_sink_driver.sv
// Directed bench for sipo_sink_driver: one task per scenario, two chained
// instances for the cascade case.
module test_sipo_sink_driver;

    localparam int CLK_PERIOD = 10;
    localparam int N_CH       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic load = 1'b0;
    logic strobe_n = 1'b1;
    logic power_en = 1'b0;

    logic            ser_out_a;
    logic            ser_out_b;
    logic [N_CH-1:0] chan_a;
    logic [N_CH-1:0] chan_b;
    logic [1:0]      err_a;
    logic [1:0]      err_b;

    int n_run  = 0;
    int n_fail = 0;
    int setup_total = 0;
    int hold_total  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sipo_sink_driver #(.N_CH(N_CH)) i_sipo_sink_driver (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .load       (load),
        .strobe_n   (strobe_n),
        .power_en   (power_en),
        .ser_out    (ser_out_a),
        .chan_on    (chan_a),
        .timing_err (err_a)
    );

    sipo_sink_driver #(.N_CH(N_CH)) i_sipo_sink_driver_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_data   (ser_out_a),
        .load       (load),
        .strobe_n   (strobe_n),
        .power_en   (power_en),
        .ser_out    (ser_out_b),
        .chan_on    (chan_b),
        .timing_err (err_b)
    );

    // Count timing fault pulses of the first instance.
    always @(posedge clk) begin
        if (rst_n && err_a[0]) setup_total++;
        if (rst_n && err_a[1]) hold_total++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        cyc(4);
        ser_clk = 1'b1;
        cyc(5);
        ser_clk = 1'b0;
        cyc(2);
    endtask

    task automatic send_byte(input logic [N_CH-1:0] v);
        for (int i = N_CH - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic pulse_load();
        load = 1'b1;
        cyc(4);
        load = 1'b0;
        cyc(4);
    endtask

    // R1: reset state of all outputs.
    task automatic t_reset();
        rst_n = 1'b0;
        cyc(5);
        check("R1 chan_on in reset", 32'(chan_a), 32'h0);
        rst_n = 1'b1;
        power_en = 1'b1;
        cyc(6);
        check("R1 chan_on after release", 32'(chan_a), 32'h0);
        check("R1 ser_out after release", 32'(ser_out_a), 32'h0);
        check("R1 timing_err after release", 32'(err_a), 32'h0);
    endtask

    // R3 and R5: load a byte, strobe it onto the channels.
    task automatic t_load_and_strobe();
        send_byte(8'hA5);
        pulse_load();
        cyc(4);
        check("R5 strobe high keeps channels dark", 32'(chan_a), 32'h0);
        strobe_n = 1'b0;
        cyc(6);
        check("R3 latched byte order on chan_on", 32'(chan_a), 32'hA5);
    endtask

    // R2: ser_out walks through the previously shifted byte.
    task automatic t_serial_out();
        logic [N_CH-1:0] prev = 8'hA5;
        check("R2 ser_out shows top stage", 32'(ser_out_a), 32'(prev[N_CH-1]));
        for (int k = 1; k < N_CH; k++) begin
            send_bit(1'b0);
            check("R2 ser_out delay line", 32'(ser_out_a), 32'(prev[N_CH-1-k]));
        end
        send_bit(1'b0);
        check("R2 ser_out after flush", 32'(ser_out_a), 32'h0);
        check("R4 chan_on unchanged by shifting", 32'(chan_a), 32'hA5);
    endtask

    // R4: latch holds while a new byte is shifted, then updates on load.
    task automatic t_hold_between_loads();
        send_byte(8'h3C);
        check("R4 latch holds old byte", 32'(chan_a), 32'hA5);
        pulse_load();
        cyc(2);
        check("R3 new byte after load", 32'(chan_a), 32'h3C);
    endtask

    // R5: output pulse width equals strobe low width.
    task automatic t_pulse_width(input int w);
        int on_cnt = 0;
        strobe_n = 1'b1;
        cyc(6);
        check("R5 dark before pulse", 32'(chan_a), 32'h0);
        strobe_n = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i == w - 1) strobe_n = 1'b1;
            if (chan_a != '0) on_cnt++;
        end
        check("R5 pulse width in cycles", 32'(on_cnt), 32'(w));
    endtask

    // R6: standby darkens outputs and ignores serial clock and load.
    task automatic t_standby();
        logic saved;
        strobe_n = 1'b0;
        cyc(6);
        check("R6 lit before standby", 32'(chan_a), 32'h3C);
        saved = ser_out_a;
        power_en = 1'b0;
        cyc(6);
        check("R6 dark in standby", 32'(chan_a), 32'h0);
        send_byte(8'hFF);
        pulse_load();
        check("R6 ser_out held in standby", 32'(ser_out_a), 32'(saved));
        check("R6 still dark in standby", 32'(chan_a), 32'h0);
        power_en = 1'b1;
        cyc(6);
        check("R6 latch pattern back", 32'(chan_a), 32'h3C);
        pulse_load();
        cyc(2);
        check("R6 shift register was not touched", 32'(chan_a), 32'h3C);
    endtask

    // R7 and R8: clean traffic raises nothing; forced faults are flagged.
    task automatic t_timing();
        int s0;
        int h0;
        check("R8 no fault on clean traffic (setup)", 32'(setup_total), 32'h0);
        check("R8 no fault on clean traffic (hold)", 32'(hold_total), 32'h0);
        s0 = setup_total;
        h0 = hold_total;
        cyc(10);
        ser_data = ~ser_data;
        cyc(1);
        ser_clk = 1'b1;
        cyc(10);
        ser_clk = 1'b0;
        cyc(10);
        check("R7 setup fault flagged", 32'(setup_total - s0), 32'h1);
        check("R7 no hold fault on setup case", 32'(hold_total - h0), 32'h0);
        s0 = setup_total;
        h0 = hold_total;
        ser_clk = 1'b1;
        cyc(1);
        ser_data = ~ser_data;
        cyc(10);
        ser_clk = 1'b0;
        cyc(10);
        check("R8 hold fault flagged", 32'(hold_total - h0), 32'h1);
        check("R8 no setup fault on hold case", 32'(setup_total - s0), 32'h0);
    endtask

    // R9: two chained blocks filled by sixteen bits.
    task automatic t_cascade();
        send_byte(8'h96);
        send_byte(8'h0F);
        pulse_load();
        strobe_n = 1'b0;
        cyc(6);
        check("R9 first block channels", 32'(chan_a), 32'h0F);
        check("R9 second block channels", 32'(chan_b), 32'h96);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++;
        n_fail++;
        $display("[TB] FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc(1);
        t_reset();
        t_load_and_strobe();
        t_serial_out();
        t_hold_between_loads();
        t_pulse_width(7);
        t_pulse_width(2);
        t_standby();
        t_timing();
        t_cascade();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule